// File: doc/BRIEF.md
# Ethernet DMA control and status register bank

This block is the software-visible register bank of an Ethernet DMA controller. A processor reaches it through a plain word-addressed read/write port. The bank keeps the ring base and current-descriptor pointers for both directions, the bus-mode, control and interrupt-enable words, and a status word. The descriptor engines report events into the status word through per-bit sticky set inputs. Software acknowledges events by writing ones to the bits it wants to clear.

A single level interrupt goes high whenever a status bit is set whose enable bit is also set. Some writes also produce one-cycle strobes toward the engines. Loading a ring base raises a base-load strobe for that direction and moves the current-descriptor pointer to the same value. A write to the transmit poll-demand address raises a kick strobe and stores nothing. The receive-enable and transmit-start bits of the control word are also brought out as level outputs.

Top module: `edma_csr`

## Requirements
- R1: Addresses on `reg_addr` are word indices, equal to the byte offset divided by four. The index map is: version 0x008, bus mode 0x3C0, transmit poll demand 0x3C1, receive ring base 0x3C3, transmit ring base 0x3C4, status 0x3C5, control 0x3C6, interrupt enable 0x3C7, current transmit descriptor 0x3D2, current receive descriptor 0x3D3. `reg_rdata` returns the addressed register in the same cycle, with no added latency.
- R2: After a synchronous active-low reset, every register reads zero and `irq` is low. The version index always reads 0x0000_1012.
- R3: A write to the status index clears each status bit whose data bit is one. Every other status bit keeps its value.
- R4: A status bit that is raised on `sts_set` is set at the next clock edge. This holds even when software clears the same bit in that cycle: the set wins.
- R5: `irq` is high exactly when the AND of status and interrupt enable is nonzero. It follows every register write and every set event at the clock edge where they take effect.
- R6: A write to the receive ring base loads the value into both the receive base and the current receive descriptor. `rx_base_ld` is high for the one cycle after the write.
- R7: A write to the transmit ring base loads the value into both the transmit base and the current transmit descriptor. `tx_base_ld` is high for the one cycle after the write.
- R8: Bit 0 of the bus-mode word is always stored as zero. Bits 31..1 store the written value.
- R9: A write to the transmit poll-demand index changes no stored register and reads back zero. `tx_poll` is high for the one cycle after the write and is low otherwise.
- R10: `rx_enable` follows bit 1 of the control word, and `tx_enable` follows bit 13 of the control word.
- R11: Reads of any index not in the map return zero. Writes to such an index, or to the version index, have no effect.
- R12: A direct write to a current-descriptor index changes only that pointer. It does not change the ring base and raises no base-load strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Write enable for the register port |
| reg_addr | input | AW (10) | Word index of the register |
| reg_wdata | input | DW (32) | Write data |
| reg_rdata | output | DW (32) | Read data for `reg_addr`, combinational |
| sts_set | input | DW (32) | Per-bit sticky status set from the engines |
| irq | output | 1 | Level interrupt |
| tx_poll | output | 1 | One-cycle transmit kick strobe |
| rx_base_ld | output | 1 | One-cycle strobe after a receive base load |
| tx_base_ld | output | 1 | One-cycle strobe after a transmit base load |
| rx_enable | output | 1 | Receive enable, control bit 1 |
| tx_enable | output | 1 | Transmit start, control bit 13 |
| rx_cur_desc | output | DW (32) | Current receive descriptor pointer |
| tx_cur_desc | output | DW (32) | Current transmit descriptor pointer |

## Verification
The clear assertion assumes that no engine sets a bit in the same cycle that software clears it. For that reason it is checked only when the set and clear masks do not overlap. The set-wins case is covered by the bench instead. The interrupt assertion assumes that software does not rewrite the interrupt enable in the cycle after a set event. The bench keeps to both assumptions: it changes inputs only on falling edges, raises set bits only in cycles of its choosing, and never writes the enable word next to a set pulse.

// File: rtl/edma_csr_pkg.sv
// Package: word indices of the DMA register bank and its fixed values.
// Assumes a word index is the byte offset divided by four.
package edma_csr_pkg;
    localparam int unsigned IDX_VERSION  = 'h008;
    localparam int unsigned IDX_BUSMODE  = 'h3C0;
    localparam int unsigned IDX_TXPOLL   = 'h3C1;
    localparam int unsigned IDX_RXBASE   = 'h3C3;
    localparam int unsigned IDX_TXBASE   = 'h3C4;
    localparam int unsigned IDX_STATUS   = 'h3C5;
    localparam int unsigned IDX_CONTROL  = 'h3C6;
    localparam int unsigned IDX_INTEN    = 'h3C7;
    localparam int unsigned IDX_TXCUR    = 'h3D2;
    localparam int unsigned IDX_RXCUR    = 'h3D3;

    localparam logic [31:0] VERSION_CODE = 32'h0000_1012;
    localparam int unsigned CTRL_RXEN_BIT = 1;
    localparam int unsigned CTRL_TXGO_BIT = 13;

    // Ring direction selector used by the generate loop.
    typedef enum logic {DIR_RX = 1'b0, DIR_TX = 1'b1} ring_dir_e;
endpackage

// File: rtl/edma_csr_status.sv
// Status word with write-one-to-clear access and sticky per-bit set inputs,
// plus the level interrupt.
// Assumes clr_mask is only meaningful while clr_we is high. A set event
// overrides a clear of the same bit in the same cycle.
module edma_csr_status #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_we,
    input  logic [DW-1:0] clr_mask,
    input  logic [DW-1:0] set_bits,
    input  logic [DW-1:0] inten,
    output logic [DW-1:0] status,
    output logic          irq
);
    logic [DW-1:0] keep_mask;

    // Bits that survive this cycle's software clear.
    assign keep_mask = clr_we ? ~clr_mask : {DW{1'b1}};

    // Status update: clear first, then OR in the set events so sets win.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & keep_mask) | set_bits;
    end

    // Interrupt level from the enabled status bits.
    assign irq = |(status & inten);

    // R3
    w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && ((clr_mask & set_bits) == '0)) |=> ((status & $past(clr_mask)) == '0));

    // R4
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_bits != '0) |=> ((status & $past(set_bits)) == $past(set_bits)));

    // R5
    irq_follows_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_bits & inten) != '0) |=> (irq || ((inten & $past(set_bits)) == '0)));
endmodule

// File: rtl/edma_csr_ring.sv
// One ring's base and current-descriptor pointer pair.
// Assumes base_we and cur_we are never high together; if they are, the base
// load takes priority and sets both pointers.
module edma_csr_ring #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          base_we,
    input  logic          cur_we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] base,
    output logic [DW-1:0] cur,
    output logic          ld_pulse
);
    // Base pointer: loaded only by a base write.
    always_ff @(posedge clk) begin
        if (!rst_n)       base <= '0;
        else if (base_we) base <= wdata;
    end

    // Current pointer: follows a base load, or takes a direct write.
    always_ff @(posedge clk) begin
        if (!rst_n)       cur <= '0;
        else if (base_we) cur <= wdata;
        else if (cur_we)  cur <= wdata;
    end

    // One-cycle base-load strobe toward the engine.
    always_ff @(posedge clk) begin
        if (!rst_n) ld_pulse <= 1'b0;
        else        ld_pulse <= base_we;
    end

    // R6
    ring_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        base_we |=> (cur == base && ld_pulse));
endmodule

// File: rtl/edma_csr.sv
// Top of the DMA register bank: address decode, plain registers, read mux,
// transmit kick strobe, and the status and ring sub-blocks.
// Assumes single-cycle writes with reg_we; reads are combinational on reg_addr.
module edma_csr
    import edma_csr_pkg::*;
#(
    parameter int AW = 10,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic [DW-1:0] sts_set,
    output logic          irq,
    output logic          tx_poll,
    output logic          rx_base_ld,
    output logic          tx_base_ld,
    output logic          rx_enable,
    output logic          tx_enable,
    output logic [DW-1:0] rx_cur_desc,
    output logic [DW-1:0] tx_cur_desc
);
    localparam int NRING = 2;

    logic          hit_busmode, hit_txpoll, hit_status, hit_control, hit_inten;
    logic [DW-1:0] busmode_q, control_q, inten_q, status_q;
    logic [DW-1:0] base_q [NRING];
    logic [DW-1:0] cur_q  [NRING];
    logic [NRING-1:0] ld_q;

    // Write decode against the word index map.
    assign hit_busmode = reg_we && (reg_addr == AW'(IDX_BUSMODE));
    assign hit_txpoll  = reg_we && (reg_addr == AW'(IDX_TXPOLL));
    assign hit_status  = reg_we && (reg_addr == AW'(IDX_STATUS));
    assign hit_control = reg_we && (reg_addr == AW'(IDX_CONTROL));
    assign hit_inten   = reg_we && (reg_addr == AW'(IDX_INTEN));

    // Bus-mode word; the soft-reset bit never stores.
    always_ff @(posedge clk) begin
        if (!rst_n)           busmode_q <= '0;
        else if (hit_busmode) busmode_q <= {reg_wdata[DW-1:1], 1'b0};
    end

    // Control and interrupt-enable words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            control_q <= '0;
            inten_q   <= '0;
        end else begin
            if (hit_control) control_q <= reg_wdata;
            if (hit_inten)   inten_q   <= reg_wdata;
        end
    end

    // Transmit kick strobe; the poll-demand write stores nothing.
    always_ff @(posedge clk) begin
        if (!rst_n) tx_poll <= 1'b0;
        else        tx_poll <= hit_txpoll;
    end

    edma_csr_status #(.DW(DW)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_we   (hit_status),
        .clr_mask (reg_wdata),
        .set_bits (sts_set),
        .inten    (inten_q),
        .status   (status_q),
        .irq      (irq)
    );

    // One pointer pair per direction, picked by the ring index.
    for (genvar g = 0; g < NRING; g++) begin : g_ring
        localparam int unsigned BASE_IDX = (g == int'(DIR_TX)) ? IDX_TXBASE : IDX_RXBASE;
        localparam int unsigned CUR_IDX  = (g == int'(DIR_TX)) ? IDX_TXCUR  : IDX_RXCUR;
        edma_csr_ring #(.DW(DW)) u_ring (
            .clk      (clk),
            .rst_n    (rst_n),
            .base_we  (reg_we && (reg_addr == AW'(BASE_IDX))),
            .cur_we   (reg_we && (reg_addr == AW'(CUR_IDX))),
            .wdata    (reg_wdata),
            .base     (base_q[g]),
            .cur      (cur_q[g]),
            .ld_pulse (ld_q[g])
        );
    end

    assign rx_base_ld  = ld_q[int'(DIR_RX)];
    assign tx_base_ld  = ld_q[int'(DIR_TX)];
    assign rx_cur_desc = cur_q[int'(DIR_RX)];
    assign tx_cur_desc = cur_q[int'(DIR_TX)];
    assign rx_enable   = control_q[CTRL_RXEN_BIT];
    assign tx_enable   = control_q[CTRL_TXGO_BIT];

    // Read mux; unmapped indices read zero.
    always_comb begin
        case (reg_addr)
            AW'(IDX_VERSION): reg_rdata = VERSION_CODE;
            AW'(IDX_BUSMODE): reg_rdata = busmode_q;
            AW'(IDX_RXBASE):  reg_rdata = base_q[int'(DIR_RX)];
            AW'(IDX_TXBASE):  reg_rdata = base_q[int'(DIR_TX)];
            AW'(IDX_STATUS):  reg_rdata = status_q;
            AW'(IDX_CONTROL): reg_rdata = control_q;
            AW'(IDX_INTEN):   reg_rdata = inten_q;
            AW'(IDX_TXCUR):   reg_rdata = cur_q[int'(DIR_TX)];
            AW'(IDX_RXCUR):   reg_rdata = cur_q[int'(DIR_RX)];
            default:          reg_rdata = '0;
        endcase
    end

    // R9
    poll_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_poll |-> $past(reg_we && (reg_addr == AW'(IDX_TXPOLL))));
endmodule

// File: tb/edma_csr_test.sv
module edma_csr_test;
    localparam int AW = 10;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic [DW-1:0] sts_set = '0;
    logic irq, tx_poll, rx_base_ld, tx_base_ld, rx_enable, tx_enable;
    logic [DW-1:0] rx_cur_desc, tx_cur_desc;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    edma_csr #(.AW(AW), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sts_set(sts_set),
        .irq(irq), .tx_poll(tx_poll), .rx_base_ld(rx_base_ld),
        .tx_base_ld(tx_base_ld), .rx_enable(rx_enable), .tx_enable(tx_enable),
        .rx_cur_desc(rx_cur_desc), .tx_cur_desc(tx_cur_desc)
    );

    localparam logic [AW-1:0] A_VER = 10'h008, A_BUS = 10'h3C0, A_POLL = 10'h3C1,
        A_RXB = 10'h3C3, A_TXB = 10'h3C4, A_STS = 10'h3C5, A_CTL = 10'h3C6,
        A_IEN = 10'h3C7, A_TXC = 10'h3D2, A_RXC = 10'h3D3;

    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Write one word; returns at the falling edge after the write took effect.
    task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic t_reset();
        logic [DW-1:0] v;
        rd(A_STS, v); check("R2 status", v, 0);
        rd(A_BUS, v); check("R2 busmode", v, 0);
        rd(A_CTL, v); check("R2 control", v, 0);
        rd(A_RXC, v); check("R2 rx cur", v, 0);
        rd(A_VER, v); check("R2 version", v, 32'h1012);
        check("R2 irq", irq, 0);
    endtask

    task automatic t_busmode();
        logic [DW-1:0] v;
        wr(A_BUS, 32'hFFFF_FFFF);
        rd(A_BUS, v); check("R8 bit0 zero", v, 32'hFFFF_FFFE);
        wr(A_BUS, 32'h0000_0A55);
        rd(A_BUS, v); check("R8 R1 bus mode", v, 32'h0000_0A54);
    endtask

    task automatic t_rings();
        logic [DW-1:0] v;
        wr(A_RXB, 32'h1000_0040);
        check("R6 rx_base_ld pulse", rx_base_ld, 1);
        check("R6 no tx strobe", tx_base_ld, 0);
        rd(A_RXB, v); check("R6 rx base", v, 32'h1000_0040);
        rd(A_RXC, v); check("R6 rx cur", v, 32'h1000_0040);
        check("R6 rx cur port", rx_cur_desc, 32'h1000_0040);
        @(negedge clk); check("R6 strobe one cycle", rx_base_ld, 0);
        wr(A_TXB, 32'h2000_0080);
        check("R7 tx_base_ld pulse", tx_base_ld, 1);
        rd(A_TXC, v); check("R7 tx cur", v, 32'h2000_0080);
        check("R7 tx cur port", tx_cur_desc, 32'h2000_0080);
        rd(A_RXC, v); check("R7 rx untouched", v, 32'h1000_0040);
        wr(A_RXC, 32'h1000_0060);
        check("R12 no strobe", rx_base_ld, 0);
        rd(A_RXC, v); check("R12 cur written", v, 32'h1000_0060);
        rd(A_RXB, v); check("R12 base kept", v, 32'h1000_0040);
        wr(A_TXC, 32'h2000_00A0);
        rd(A_TXB, v); check("R12 tx base kept", v, 32'h2000_0080);
        check("R12 tx cur port", tx_cur_desc, 32'h2000_00A0);
    endtask

    task automatic t_status_irq();
        logic [DW-1:0] v;
        @(negedge clk); sts_set = 32'h0000_0005;
        @(negedge clk); sts_set = '0;
        rd(A_STS, v); check("R4 set sticky", v, 32'h0000_0005);
        check("R5 masked irq low", irq, 0);
        wr(A_IEN, 32'h0000_0001);
        check("R5 irq high", irq, 1);
        wr(A_STS, 32'h0000_0040);
        rd(A_STS, v); check("R3 other bits kept", v, 32'h0000_0005);
        check("R5 irq still high", irq, 1);
        wr(A_STS, 32'h0000_0001);
        rd(A_STS, v); check("R3 bit cleared", v, 32'h0000_0004);
        check("R5 irq low after clear", irq, 0);
        wr(A_IEN, 32'h0000_0004);
        check("R5 irq on enable", irq, 1);
        wr(A_STS, 32'hFFFF_FFFF);
        check("R3 clear all irq", irq, 0);
    endtask

    task automatic t_set_wins();
        logic [DW-1:0] v;
        @(negedge clk); sts_set = 32'h0000_0001;
        @(negedge clk); sts_set = '0;
        @(negedge clk);
        reg_we = 1'b1; reg_addr = A_STS; reg_wdata = 32'h0000_0041;
        sts_set = 32'h0000_0040;
        @(negedge clk);
        reg_we = 1'b0; sts_set = '0;
        rd(A_STS, v); check("R4 set wins over clear", v, 32'h0000_0040);
        wr(A_IEN, 32'h0000_0040);
        check("R5 irq from won bit", irq, 1);
        wr(A_STS, 32'h0000_0040);
        check("R5 irq cleared", irq, 0);
    endtask

    task automatic t_poll();
        logic [DW-1:0] b, c, s, v;
        rd(A_BUS, b); rd(A_CTL, c); rd(A_STS, s);
        check("R9 idle strobe", tx_poll, 0);
        wr(A_POLL, 32'hFFFF_FFFF);
        check("R9 tx_poll pulse", tx_poll, 1);
        rd(A_POLL, v); check("R9 reads zero", v, 0);
        rd(A_BUS, v); check("R9 busmode kept", v, b);
        rd(A_CTL, v); check("R9 control kept", v, c);
        rd(A_STS, v); check("R9 status kept", v, s);
        @(negedge clk); check("R9 strobe one cycle", tx_poll, 0);
    endtask

    task automatic t_control();
        logic [DW-1:0] v;
        wr(A_CTL, 32'h0000_2002);
        check("R10 rx_enable", rx_enable, 1);
        check("R10 tx_enable", tx_enable, 1);
        rd(A_CTL, v); check("R10 control", v, 32'h0000_2002);
        wr(A_CTL, 32'h0000_2000);
        check("R10 rx off", rx_enable, 0);
        check("R10 tx stays", tx_enable, 1);
        wr(A_CTL, 32'h0000_0002);
        check("R10 tx off", tx_enable, 0);
    endtask

    task automatic t_unmapped();
        logic [DW-1:0] v;
        wr(10'h100, 32'hDEAD_BEEF);
        rd(10'h100, v); check("R11 unmapped zero", v, 0);
        rd(10'h3FF, v); check("R11 top index zero", v, 0);
        wr(A_VER, 32'h0);
        rd(A_VER, v); check("R11 version fixed", v, 32'h1012);
        rd(A_BUS, v); check("R11 bus mode kept", v, 32'h0000_0A54);
        check("R11 irq unchanged", irq, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_busmode();
        t_rings();
        t_status_irq();
        t_set_wins();
        t_poll();
        t_control();
        t_unmapped();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule